// File: doc/BRIEF.md
# Clock Status and Write-Unlock Register

This block is the volatile status byte of a real-time clock register map. It gathers hardware conditions into one readable byte: operation from the backup supply, oscillator failure, two alarm-match flags and a flag that records a complete loss of power. It also holds a two-stage write-unlock that must be opened before any write to the clock and control registers may land.

A bus front end, outside this block, presents a byte-wide register interface. It supplies an address, a write strobe with data, and one-cycle pulses marking the start and the end of a read. The block returns the assembled status byte and a write-enable for the protected register space. A protected write that arrives while the unlock is closed is dropped here. The bus side still acknowledges it, so software sees no error. Alarm flags clear when a status read ends. A flag is cleared only if it was already set when that read began, so an alarm that fires during the read is never lost.

Top module: `rtcstat_reg`

## Requirements
- R1: After reset, with all hardware inputs low, `stat_byte` reads 0x01 (only the power-loss flag, bit 0, is set), and `wr_permit` is 0.
- R2: Bit 7 of `stat_byte` follows `on_backup` and bit 4 follows `osc_bad` in the same cycle. Bit 3 always reads 0.
- R3: A pulse on `alarm_hit[0]` sets bit 5, and a pulse on `alarm_hit[1]` sets bit 6, in the cycle after the pulse. Both flags stay set until they are cleared.
- R4: A read of the status address starts with `rd_start` and ends with `rd_end`. At the end of that read, an alarm flag that was set when the read started is cleared. A flag set after the start stays set.
- R5: A read started at any other address does not clear the alarm flags.
- R6: Writing 0x02 to the status address sets the first latch, WEL (bit 1), and clears the second latch, RWEL (bit 2).
- R7: Writing 0x06 to the status address sets both latches, but only when WEL is already 1. When WEL is 0, the write leaves both latches at 0.
- R8: Writing 0x00 to the status address clears both latches. Any other value written to the status address leaves both latches unchanged.
- R9: `wr_permit` is 1 exactly when WEL and RWEL are both 1. `ctl_wr_en` is raised, in the same cycle as `bus_wr`, only for a write that targets the protected range [CTL_BASE, CTL_LAST] excluding the status address, and only while `wr_permit` is 1. Any other protected write is dropped.
- R10: The power-loss flag (bit 0) is set in the cycle after a `pwr_lost` pulse. It is cleared after a write that raises `ctl_wr_en`. Writes to the status address do not clear it.
- R11: If an alarm match arrives in the same cycle that a read ends and would clear that flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| rd_start | input | 1 | Pulse when a read begins at `bus_addr` |
| rd_end | input | 1 | Pulse when the last data bit of a read has gone out |
| alarm_hit | input | 2 | Alarm match pulses, index 0 and 1 |
| on_backup | input | 1 | High while running from the backup supply |
| osc_bad | input | 1 | High while the oscillator is faulty |
| pwr_lost | input | 1 | Pulse on power-up after total supply loss |
| stat_byte | output | 8 | Assembled status byte |
| wr_permit | output | 1 | Both write-unlock latches are set |
| ctl_wr_en | output | 1 | Qualified write into the protected register space |

## Verification
A wrong lock state shows up as a `ctl_wr_en` pulse where none should occur, or a missing one. It also shows one cycle after the status write, in bits 2:1 of `stat_byte`. If the read-begin snapshot is lost, one of two things happens. An alarm raised during a read disappears at `rd_end`, or a flag that was present at the start survives the read. Either way the error is visible in the cycle after `rd_end`. A bad power-loss flag shows in bit 0 one cycle after `pwr_lost` or after a protected write.

// File: rtl/rtcstat_pkg.sv
package rtcstat_pkg;
   localparam int STAT_W   = 8;
   localparam int BIT_BAT  = 7;
   localparam int BIT_AL1  = 6;
   localparam int BIT_AL0  = 5;
   localparam int BIT_OSC  = 4;
   localparam int BIT_RSV  = 3;
   localparam int BIT_RWEL = 2;
   localparam int BIT_WEL  = 1;
   localparam int BIT_RTCF = 0;

   localparam logic [STAT_W-1:0] CMD_LOCK   = 8'h00;
   localparam logic [STAT_W-1:0] CMD_STAGE1 = 8'h02;
   localparam logic [STAT_W-1:0] CMD_STAGE2 = 8'h06;

   // bit 0 = WEL, bit 1 = RWEL
   typedef enum logic [1:0] {
      LK_CLOSED = 2'b00,
      LK_STAGE1 = 2'b01,
      LK_OPEN   = 2'b11
   } lock_e;
endpackage

// File: rtl/rtcstat_lock.sv
module rtcstat_lock
   import rtcstat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stat,
   input  logic [STAT_W-1:0] wdata,
   output logic              wel,
   output logic              rwel
);
   lock_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (wr_stat) begin
         case (wdata)
            CMD_LOCK:   state_d = LK_CLOSED;
            CMD_STAGE1: state_d = LK_STAGE1;
            CMD_STAGE2: if (state_q != LK_CLOSED) state_d = LK_OPEN;
            default:    state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LK_CLOSED;
      else        state_q <= state_d;
   end

   assign wel  = state_q[0];
   assign rwel = state_q[1];
endmodule

// File: rtl/rtcstat_alarm.sv
module rtcstat_alarm #(
   parameter bit SNAPSHOT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic rd_begin,
   input  logic rd_done,
   output logic flag
);
   logic flag_q;
   logic clr_ok;

   generate
      if (SNAPSHOT) begin : g_snap
         logic armed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        armed_q <= 1'b0;
            else if (rd_begin) armed_q <= flag_q;
            else if (rd_done)  armed_q <= 1'b0;
         end
         assign clr_ok = armed_q;
      end else begin : g_plain
         logic unused_begin;
         assign unused_begin = rd_begin;
         assign clr_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flag_q <= 1'b0;
      else if (hit)                flag_q <= 1'b1;
      else if (rd_done && clr_ok)  flag_q <= 1'b0;
   end

   assign flag = flag_q;
endmodule

// File: rtl/rtcstat_lossflag.sv
module rtcstat_lossflag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_ev,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b1;
      else if (set_ev) flag <= 1'b1;
      else if (clr_ev) flag <= 1'b0;
   end
endmodule

// File: rtl/rtcstat_reg.sv
module rtcstat_reg
   import rtcstat_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int STAT_ADDR = 'h003F,
   parameter int CTL_BASE  = 'h0030,
   parameter int CTL_LAST  = 'h003F,
   parameter int N_ALARM   = 2,
   parameter bit SNAPSHOT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   input  logic              rd_start,
   input  logic              rd_end,
   input  logic [1:0]        alarm_hit,
   input  logic              on_backup,
   input  logic              osc_bad,
   input  logic              pwr_lost,
   output logic [7:0]        stat_byte,
   output logic              wr_permit,
   output logic              ctl_wr_en
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] CTL_LO = ADDR_W'(CTL_BASE);
   localparam logic [ADDR_W-1:0] CTL_HI = ADDR_W'(CTL_LAST);

   if (N_ALARM != 2) begin : g_bad_alarm
      $error("rtcstat_reg: status layout holds exactly two alarm flags");
   end
   if (CTL_LAST < CTL_BASE) begin : g_bad_range
      $error("rtcstat_reg: protected range is empty");
   end
   if (ADDR_W < 32 && (STAT_ADDR >= (1 << ADDR_W) || CTL_LAST >= (1 << ADDR_W))) begin : g_bad_addr
      $error("rtcstat_reg: address does not fit ADDR_W");
   end

   logic hit_stat, in_ctl, wr_stat;
   logic rd_open_q, rd_begin, rd_done;
   logic wel, rwel, rtcf;
   logic [N_ALARM-1:0] al;

   assign hit_stat  = (bus_addr == STAT_A);
   assign in_ctl    = (bus_addr >= CTL_LO) && (bus_addr <= CTL_HI) && !hit_stat;
   assign wr_stat   = bus_wr && hit_stat;
   assign rd_begin  = rd_start && hit_stat;
   assign rd_done   = rd_end && rd_open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_open_q <= 1'b0;
      else if (rd_begin) rd_open_q <= 1'b1;
      else if (rd_end)   rd_open_q <= 1'b0;
   end

   rtcstat_lock u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stat (wr_stat),
      .wdata   (bus_wdata),
      .wel     (wel),
      .rwel    (rwel)
   );

   assign wr_permit = wel && rwel;
   assign ctl_wr_en = bus_wr && in_ctl && wr_permit;

   for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
      rtcstat_alarm #(.SNAPSHOT(SNAPSHOT)) u_al (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (alarm_hit[i]),
         .rd_begin (rd_begin),
         .rd_done  (rd_done),
         .flag     (al[i])
      );
   end

   rtcstat_lossflag u_loss (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (pwr_lost),
      .clr_ev (ctl_wr_en),
      .flag   (rtcf)
   );

   always_comb begin
      stat_byte           = '0;
      stat_byte[BIT_BAT]  = on_backup;
      stat_byte[BIT_AL1]  = al[1];
      stat_byte[BIT_AL0]  = al[0];
      stat_byte[BIT_OSC]  = osc_bad;
      stat_byte[BIT_RSV]  = 1'b0;
      stat_byte[BIT_RWEL] = rwel;
      stat_byte[BIT_WEL]  = wel;
      stat_byte[BIT_RTCF] = rtcf;
   end
endmodule

// File: rtl/rtcstat_chk.sv
module rtcstat_chk #(
   parameter int ADDR_W    = 16,
   parameter int STAT_ADDR = 'h003F
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [7:0]        bus_wdata,
   input logic [1:0]        alarm_hit,
   input logic              pwr_lost,
   input logic [7:0]        stat_byte,
   input logic              ctl_wr_en
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   AST_AL0_SETS: assert property (@(posedge clk) disable iff (!rst_n) alarm_hit[0] |=> stat_byte[5]); // R3
   AST_AL1_SETS: assert property (@(posedge clk) disable iff (!rst_n) alarm_hit[1] |=> stat_byte[6]); // R3
   AST_RWEL_AFTER_WEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat_byte[2]) |-> $past(stat_byte[1])); // R7
   AST_ZERO_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STAT_A && bus_wdata == 8'h00) |=> (stat_byte[2:1] == 2'b00)); // R8
   AST_CTL_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr_en |-> (stat_byte[2] && stat_byte[1])); // R9
   AST_LOSS_SETS: assert property (@(posedge clk) disable iff (!rst_n) pwr_lost |=> stat_byte[0]); // R10
   AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ctl_wr_en && !pwr_lost) |=> !stat_byte[0]); // R10
endmodule

bind rtcstat_reg rtcstat_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .alarm_hit (alarm_hit),
   .pwr_lost  (pwr_lost),
   .stat_byte (stat_byte),
   .ctl_wr_en (ctl_wr_en)
);

// File: tb/test_rtcstat_reg.sv
module test_rtcstat_reg;
   localparam int AW = 16;
   localparam logic [AW-1:0] A_STAT = 16'h003F;
   localparam logic [AW-1:0] A_CTL  = 16'h0030;
   localparam logic [AW-1:0] A_OUT  = 16'h0040;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic rd_start = 1'b0, rd_end = 1'b0;
   logic [1:0] alarm_hit = '0;
   logic on_backup = 1'b0, osc_bad = 1'b0, pwr_lost = 1'b0;
   logic [7:0] stat_byte;
   logic wr_permit, ctl_wr_en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rtcstat_reg i_rtcstat_reg (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .rd_start(rd_start), .rd_end(rd_end),
      .alarm_hit(alarm_hit), .on_backup(on_backup), .osc_bad(osc_bad),
      .pwr_lost(pwr_lost), .stat_byte(stat_byte), .wr_permit(wr_permit),
      .ctl_wr_en(ctl_wr_en)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   // drive on a falling edge, return on the next falling edge; en = ctl_wr_en mid-cycle
   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output logic en);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      #2 en = ctl_wr_en;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pulse_alarm(input logic [1:0] m);
      alarm_hit = m;
      @(negedge clk);
      alarm_hit = '0;
   endtask

   task automatic rd_begin(input logic [AW-1:0] a);
      bus_addr = a; rd_start = 1'b1;
      @(negedge clk);
      rd_start = 1'b0;
   endtask

   task automatic rd_finish();
      rd_end = 1'b1;
      @(negedge clk);
      rd_end = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 reset status", stat_byte, 8'h01);
      check("R1 reset permit", {7'd0, wr_permit}, 8'h00);
   endtask

   task automatic t_live();
      on_backup = 1'b1; osc_bad = 1'b1;
      #1 check("R2 live bits, bit3 zero", stat_byte, 8'h91);
      on_backup = 1'b0;
      #1 check("R2 backup drop", stat_byte, 8'h11);
      osc_bad = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_alarm_set();
      pulse_alarm(2'b01);
      check("R3 alarm0 sets bit5", stat_byte, 8'h21);
      pulse_alarm(2'b10);
      check("R3 alarm1 sets bit6", stat_byte, 8'h61);
      @(negedge clk);
      check("R3 flags hold", stat_byte, 8'h61);
      rd_begin(A_STAT);
      rd_finish();
      check("R4 full clear", stat_byte, 8'h01);
   endtask

   task automatic t_read_snapshot();
      pulse_alarm(2'b01);
      rd_begin(A_STAT);
      pulse_alarm(2'b10);
      rd_finish();
      check("R4 only pre-read flag cleared", stat_byte, 8'h41);
      rd_begin(A_STAT);
      rd_finish();
      check("R4 second read clears", stat_byte, 8'h01);
   endtask

   task automatic t_read_other();
      pulse_alarm(2'b01);
      rd_begin(A_CTL);
      rd_finish();
      check("R5 other-address read keeps flag", stat_byte, 8'h21);
   endtask

   task automatic t_set_wins();
      rd_begin(A_STAT);
      alarm_hit = 2'b01; rd_end = 1'b1;
      @(negedge clk);
      alarm_hit = '0; rd_end = 1'b0;
      check("R11 set beats clear", stat_byte, 8'h21);
      rd_begin(A_STAT);
      rd_finish();
      check("R4 cleared after", stat_byte, 8'h01);
   endtask

   task automatic t_unlock();
      logic en;
      wr(A_STAT, 8'h06, en);
      check("R7 stage2 while closed ignored", stat_byte, 8'h01);
      wr(A_STAT, 8'h02, en);
      check("R6 stage1 sets WEL", stat_byte, 8'h03);
      check("R9 permit low with WEL only", {7'd0, wr_permit}, 8'h00);
      wr(A_CTL, 8'h5A, en);
      check("R9 protected write dropped", {7'd0, en}, 8'h00);
      check("R10 dropped write keeps loss flag", stat_byte, 8'h03);
      wr(A_STAT, 8'h04, en);
      check("R8 other pattern ignored", stat_byte, 8'h03);
      wr(A_STAT, 8'h06, en);
      check("R7 stage2 opens", stat_byte, 8'h07);
      check("R9 permit high", {7'd0, wr_permit}, 8'h01);
      wr(A_OUT, 8'h11, en);
      check("R9 outside range dropped", {7'd0, en}, 8'h00);
      wr(A_STAT, 8'h06, en);
      check("R10 status write keeps loss flag", stat_byte, 8'h07);
      wr(A_CTL, 8'h22, en);
      check("R9 protected write passes", {7'd0, en}, 8'h01);
      check("R10 loss flag cleared", stat_byte, 8'h06);
      wr(A_STAT, 8'h02, en);
      check("R6 stage1 drops RWEL", stat_byte, 8'h02);
      wr(A_STAT, 8'h06, en);
      wr(A_STAT, 8'h00, en);
      check("R8 zero write closes", stat_byte, 8'h00);
      check("R9 permit low after close", {7'd0, wr_permit}, 8'h00);
   endtask

   task automatic t_loss();
      logic en;
      pwr_lost = 1'b1;
      @(negedge clk);
      pwr_lost = 1'b0;
      check("R10 loss flag set", stat_byte, 8'h01);
      wr(A_STAT, 8'h02, en);
      wr(A_STAT, 8'h06, en);
      pwr_lost = 1'b1;
      wr(A_CTL, 8'h33, en);
      pwr_lost = 1'b0;
      check("R10 set beats clear", stat_byte, 8'h07);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_live();
      t_alarm_set();
      t_read_snapshot();
      t_read_other();
      t_set_wins();
      t_unlock();
      t_loss();
      finish_run();
   end
endmodule